// File: doc/BRIEF.md
# Synchronous Serial Master Engine on a USART Core

This block runs a USART shift core as a master for a four-wire synchronous serial bus. Bytes come in on a valid/ready stream and pass through a one-entry transmit buffer into a shift register. The engine generates the serial clock and shifts each byte out on the data-out line. In the same frame it samples the data-in line. When a frame ends, the received byte is placed in a one-entry receive buffer and presented on a second valid/ready stream.

A seven-bit control word, written with a strobe and readable at any time, selects the following:
- transmitter enable and receiver enable;
- data order;
- clock phase and clock polarity;
- interrupt enables for "buffer empty" and "transfer complete".

A global interrupt enable pin gates the interrupt request.

Back-pressure rules:
- On the transmit stream, `tx_ready` is high only while the buffer is empty and the transmitter is enabled. A byte is taken in any cycle where `tx_valid` and `tx_ready` are both high. The source must hold `tx_data` until that cycle.
- The receive stream cannot stall the bus master. If a byte is not popped (`rx_ready`) before the next frame ends, it is overwritten.

Control-word layout: bit 0 clock polarity, bit 1 clock phase, bit 2 LSB-first, bit 3 transmitter enable, bit 4 receiver enable, bit 5 empty-interrupt enable, bit 6 complete-interrupt enable.

Top module: `usart_spi_master`

## Requirements
- R1: After reset, `cfg_rdata` is 7'h06 (LSB-first=1, phase=1, polarity=0, both enables and both interrupt enables 0). Also after reset: `dre_flag`=1, `txc_flag`=0, `rx_valid`=0, `sck`=0, `mosi_oe`=0 and `irq`=0.
- R2: `tx_ready` = buffer empty AND transmitter enable. `dre_flag` is high exactly when the buffer is empty, and it drops in the cycle after a byte is accepted. A buffered byte moves into an idle shift register on the next clock.
- R3: A frame is 16 half-periods of DIV clock cycles each, starting the cycle after the byte leaves the buffer. `sck` makes 16 transitions per frame and rests at the polarity level between frames.
- R4: With bit 2 = 1 the LSB is shifted out first, with bit 2 = 0 the MSB is shifted out first. `mosi` is 1 while no frame runs.
- R5: With phase 0, data is set up before the leading edge and sampled on it. With phase 1, data changes on the leading edge and is sampled on the trailing edge. All four modes return the byte sent by the slave.
- R6: Bit 0 sets the idle level of `sck`.
- R7: When a frame ends with the receiver enabled, the received byte is loaded and `rx_valid` rises in the same cycle. `rx_ready` empties the buffer. An unread byte is overwritten by the next frame.
- R8: Clearing the receiver enable flushes the receive buffer (`rx_valid` falls on the next clock).
- R9: When the transmitter enable is cleared, `tx_ready` falls at once. `mosi_oe` stays 1 until both the buffer and the shift register are empty.
- R10: With only the receiver enabled, no frame starts and `sck` stays idle.
- R11: `txc_flag` is set when a frame ends while the buffer is empty. It is cleared by a `txc_clr` pulse or a `txc_ack` pulse.
- R12: `irq` = `gie` AND ((complete-interrupt enable AND `txc_flag`) OR (empty-interrupt enable AND `dre_flag`)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word write value |
| cfg_rdata | output | 7 | Current control word |
| gie | input | 1 | Global interrupt enable |
| txc_clr | input | 1 | Write-one clear of the transfer-complete flag |
| txc_ack | input | 1 | Interrupt-serviced pulse, also clears the flag |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit buffer can accept |
| rx_valid | output | 1 | Receive buffer holds a byte |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | Pop the receive buffer |
| dre_flag | output | 1 | Transmit buffer empty |
| txc_flag | output | 1 | Transfer complete |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Transmitter is driving the data-out pin |
| miso | input | 1 | Serial data in |

## Verification
The bench feeds the data-out line back inverted into the data-in line. In each of the four clock modes, and with both data orders, the received byte must be the complement of the byte sent. A core that samples on the wrong edge returns a neighbouring bit, and a core with a reversed order shows wrong `mosi` bits against the model.

The bench clears the transmitter enable while one byte is shifting and another waits in the buffer. A design that stops at once drops `mosi_oe` mid-frame or loses the second byte. A design that never stops keeps `mosi_oe` high afterwards.

Further corner cases:
- A receiver-only setting must produce no clock edges.
- A receiver disable must empty the buffer.
- Two back-to-back frames must overwrite the unread byte.
- The interrupt request is checked with the global enable both low and high, and the complete flag is cleared by both the clear pin and the acknowledge pin.

// File: rtl/usm_pkg.sv
package usm_pkg;
  // Control word, bit 6 down to bit 0.
  typedef struct packed {
    logic tc_ie;
    logic dre_ie;
    logic rx_en;
    logic tx_en;
    logic lsb_first;
    logic cpha;
    logic cpol;
  } usm_ctrl_t;

  localparam int CTRL_W = $bits(usm_ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RST = 7'b000_0110;
endpackage

// File: rtl/usm_ctrl_reg.sv
module usm_ctrl_reg
  import usm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CTRL_W-1:0]  wdata,
  output usm_ctrl_t          ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= usm_ctrl_t'(CTRL_RST);
    else if (we) ctrl_q <= usm_ctrl_t'(wdata);
  end
endmodule

// File: rtl/usm_half_timer.sv
module usm_half_timer #(
  parameter int DIV    = 2,
  parameter int HALVES = 16,
  localparam int CW    = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int HW    = $clog2(HALVES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          half_end,
  output logic [HW-1:0] hidx
);
  logic [CW-1:0] cnt;

  assign half_end = run && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hidx <= '0;
    end else if (!run) begin
      cnt  <= '0;
      hidx <= '0;
    end else if (half_end) begin
      cnt  <= '0;
      hidx <= hidx + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !half_end |=> $stable(hidx));
endmodule

// File: rtl/usm_shifter.sv
module usm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift_ev,
  input  logic         sample_ev,
  input  logic         lsb_first,
  input  logic         miso,
  output logic         mosi_bit,
  output logic [W-1:0] rx_next
);
  logic [W-1:0] tx_sh, rx_sh;

  assign mosi_bit = lsb_first ? tx_sh[0] : tx_sh[W-1];

  always_comb begin
    rx_next = rx_sh;
    if (sample_ev)
      rx_next = lsb_first ? {miso, rx_sh[W-1:1]} : {rx_sh[W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load)
        tx_sh <= load_data;
      else if (shift_ev)
        tx_sh <= lsb_first ? {1'b0, tx_sh[W-1:1]} : {tx_sh[W-2:0], 1'b0};
      rx_sh <= rx_next;
    end
  end
endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
  import usm_pkg::*;
#(
  parameter int DIV = 2,
  parameter int W   = 8,
  localparam int HALVES = 2 * W,
  localparam int HW     = $clog2(HALVES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              gie,
  input  logic              txc_clr,
  input  logic              txc_ack,
  input  logic              tx_valid,
  input  logic [W-1:0]      tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [W-1:0]      rx_data,
  input  logic              rx_ready,
  output logic              dre_flag,
  output logic              txc_flag,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso
);
  usm_ctrl_t     ctrl;
  logic          txb_full, busy, half_end, start, done, accept;
  logic          lead_next, trail_next, shift_ev, sample_ev, mosi_bit;
  logic [W-1:0]  txb_data, rx_next;
  logic [HW-1:0] hidx;

  usm_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .ctrl_q(ctrl)
  );

  usm_half_timer #(.DIV(DIV), .HALVES(HALVES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_end(half_end), .hidx(hidx)
  );

  assign accept     = tx_valid && tx_ready;
  assign start      = !busy && txb_full;
  assign done       = half_end && (hidx == HW'(HALVES - 1));
  assign lead_next  = half_end && !hidx[0];
  assign trail_next = half_end && hidx[0];

  // Phase picks which edge shifts and which samples.
  always_comb begin
    if (ctrl.cpha) begin
      shift_ev  = lead_next && (hidx != '0);
      sample_ev = trail_next;
    end else begin
      shift_ev  = trail_next && !done;
      sample_ev = lead_next;
    end
  end

  usm_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(txb_data),
    .shift_ev(shift_ev), .sample_ev(sample_ev), .lsb_first(ctrl.lsb_first),
    .miso(miso), .mosi_bit(mosi_bit), .rx_next(rx_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txb_full <= 1'b0;
      txb_data <= '0;
      busy     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      txc_flag <= 1'b0;
    end else begin
      if (accept) begin
        txb_full <= 1'b1;
        txb_data <= tx_data;
      end else if (start) begin
        txb_full <= 1'b0;
      end

      if (start)     busy <= 1'b1;
      else if (done) busy <= 1'b0;

      if (!ctrl.rx_en) rx_valid <= 1'b0;
      else if (done) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_next;
      end else if (rx_ready) rx_valid <= 1'b0;

      if (done && !txb_full)        txc_flag <= 1'b1;
      else if (txc_clr || txc_ack)  txc_flag <= 1'b0;
    end
  end

  assign cfg_rdata = ctrl;
  assign tx_ready  = !txb_full && ctrl.tx_en;
  assign dre_flag  = !txb_full;
  assign sck       = ctrl.cpol ^ (busy && hidx[0]);
  assign mosi      = busy ? mosi_bit : 1'b1;
  assign mosi_oe   = ctrl.tx_en || txb_full || busy;
  assign irq       = gie && ((ctrl.tc_ie && txc_flag) || (ctrl.dre_ie && dre_flag));

  // R2
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !dre_flag);

  // R8
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.rx_en |=> !rx_valid);

  // R11
  txc_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_flag) |-> $past(busy));

  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !shift_ev && !done && !cfg_we |=> $stable(mosi));

  // R9
  oe_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> mosi_oe);
endmodule

// File: tb/usart_spi_master_tb_top.sv
module usart_spi_master_tb_top;
  localparam int DIV = 2;
  localparam int FRAME = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, gie = 0, txc_clr = 0, txc_ack = 0, tx_valid = 0, rx_ready = 0;
  logic [6:0] cfg_wdata = '0, cfg_rdata;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_ready, rx_valid, dre_flag, txc_flag, irq, sck, mosi, mosi_oe, miso;

  always #10 clk = ~clk;
  assign miso = ~mosi;

  usart_spi_master #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .gie(gie), .txc_clr(txc_clr), .txc_ack(txc_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .dre_flag(dre_flag), .txc_flag(txc_flag), .irq(irq), .sck(sck),
    .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
  );

  int checks = 0, errors = 0, cyc = 0, sck_tog = 0;
  logic prev_sck = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] txq[$];
  logic [6:0] m_ctrl;
  logic [7:0] m_frame, m_rxd;
  bit m_busy, m_rxv, m_txc, m_acc;
  int m_t;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); m_ctrl = 7'h06; m_busy = 0; m_t = 0; m_rxv = 0;
      m_rxd = 0; m_txc = 0; m_acc = 0; m_frame = 0;
    end else begin
      bit done, start, acc;
      done  = m_busy && (m_t == FRAME - 1);
      start = !m_busy && (txq.size() != 0);
      acc   = tx_valid && (txq.size() == 0) && m_ctrl[3];
      if (!m_ctrl[4]) m_rxv = 0;
      else if (done) begin m_rxv = 1; m_rxd = ~m_frame; end
      else if (rx_ready) m_rxv = 0;
      if (done && txq.size() == 0) m_txc = 1;
      else if (txc_clr || txc_ack) m_txc = 0;
      if (done) m_busy = 0; else if (m_busy) m_t++;
      if (start) begin m_busy = 1; m_t = 0; m_frame = txq.pop_front(); end
      if (acc) txq.push_back(tx_data);
      m_acc = acc;
      if (cfg_we) m_ctrl = cfg_wdata;
    end
  end

  function automatic logic exp_mosi();
    int h, idx;
    if (!m_busy) return 1'b1;
    h = m_t / DIV;
    idx = m_ctrl[1] ? ((h == 0) ? 0 : (h - 1) / 2) : h / 2;
    return m_ctrl[2] ? m_frame[idx] : m_frame[7 - idx];
  endfunction

  // Compare on every clock, midway between the edges
  always begin
    @(negedge clk); #5;
    if (rst_n) begin
      logic e_sck, e_irq, e_dre;
      e_dre = (txq.size() == 0);
      e_sck = m_ctrl[0] ^ (m_busy && ((m_t / DIV) % 2 == 1));
      e_irq = gie && ((m_ctrl[6] && m_txc) || (m_ctrl[5] && e_dre));
      chk(cfg_rdata == m_ctrl, "R1 cfg_rdata", cfg_rdata, m_ctrl);
      chk(tx_ready == (e_dre && m_ctrl[3]), "R2 tx_ready", tx_ready, e_dre && m_ctrl[3]);
      chk(dre_flag == e_dre, "R2 dre_flag", dre_flag, e_dre);
      chk(sck == e_sck, "R3 sck", sck, e_sck);
      chk(mosi == exp_mosi(), "R4 mosi", mosi, exp_mosi());
      chk(mosi_oe == (m_ctrl[3] || !e_dre || m_busy), "R9 mosi_oe", mosi_oe, m_ctrl[3] || !e_dre || m_busy);
      chk(rx_valid == m_rxv, "R7 rx_valid", rx_valid, m_rxv);
      if (m_rxv) chk(rx_data == m_rxd, "R7 rx_data", rx_data, m_rxd);
      chk(txc_flag == m_txc, "R11 txc_flag", txc_flag, m_txc);
      chk(irq == e_irq, "R12 irq", irq, e_irq);
      if (sck !== prev_sck) sck_tog++;
    end
    prev_sck = sck;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr_cfg(input logic [6:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk); tx_valid = 1; tx_data = b;
    do @(negedge clk); while (!m_acc);
    tx_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy || txq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    chk(cfg_rdata == 7'h06, "R1 reset ctrl", cfg_rdata, 7'h06);
    chk(dre_flag && !txc_flag && !rx_valid && !sck && !mosi_oe && !irq,
        "R1 reset flags", {dre_flag, txc_flag, rx_valid, sck, mosi_oe, irq}, 6'b100000);

    // R7 back-to-back frames, second overwrites first
    wr_cfg(7'h1E);
    push(8'hA5);
    push(8'h3C);
    wait_idle();
    chk(rx_valid && rx_data == 8'hC3, "R7 overwrite", rx_data, 8'hC3);
    pop();
    chk(!rx_valid, "R7 pop", rx_valid, 0);

    // R3 R5 R6 all modes, both orders
    for (int o = 0; o < 2; o++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] b;
        b = 8'h5A ^ 8'(m * 37 + o * 91);
        wr_cfg(7'h18 | 7'(o << 2) | 7'(m));
        @(negedge clk); sck_tog = 0;
        push(b);
        wait_idle();
        chk(sck_tog == 16, "R3 sck transitions", sck_tog, 16);
        chk(sck == m[0], "R6 idle level", sck, m[0]);
        chk(rx_valid && rx_data == ~b, "R5 received byte", rx_data, ~b);
        pop();
      end
    end

    // R8 receiver disable flushes
    wr_cfg(7'h1E);
    push(8'h77);
    wait_idle();
    chk(rx_valid, "R8 byte present", rx_valid, 1);
    wr_cfg(7'h0E);
    @(negedge clk);
    chk(!rx_valid, "R8 flushed", rx_valid, 0);

    // R9 deferred transmitter disable
    wr_cfg(7'h1E);
    push(8'h11);
    push(8'h22);
    wr_cfg(7'h16);
    #1;
    chk(mosi_oe && !tx_ready, "R9 still driving", {mosi_oe, tx_ready}, 2'b10);
    wait_idle();
    chk(!mosi_oe, "R9 released", mosi_oe, 0);
    chk(rx_data == 8'hDD, "R9 pending byte sent", rx_data, 8'hDD);

    // R10 receiver alone makes no clock
    wr_cfg(7'h10);
    @(negedge clk); sck_tog = 0;
    repeat (100) @(negedge clk);
    chk(sck_tog == 0, "R10 no clock", sck_tog, 0);

    // R11 R12 interrupts
    wr_cfg(7'h5E);
    push(8'h96);
    wait_idle();
    #1;
    chk(txc_flag && !irq, "R12 gie low", {txc_flag, irq}, 2'b10);
    gie = 1; #1;
    chk(irq, "R12 gie high", irq, 1);
    @(negedge clk); txc_clr = 1; @(negedge clk); txc_clr = 0; #1;
    chk(!txc_flag && !irq, "R11 clear", {txc_flag, irq}, 2'b00);
    wr_cfg(7'h3E); #1;
    chk(irq, "R12 empty irq", irq, 1);
    push(8'h0F);
    wait_idle();
    @(negedge clk); txc_ack = 1; @(negedge clk); txc_ack = 0; #1;
    chk(!txc_flag, "R11 ack", txc_flag, 0);
    gie = 0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule